// File: doc/BRIEF.md
# Dual-Clock Retransmit FIFO

This block carries 36-bit words from a write port to a read port. Each port has its own free-running clock, and the two clocks may be unrelated or the very same clock. Storage is a dual-clock memory of 1024 words. Pointers cross between the domains as Gray codes through a two-stage synchronizer. Because of that latency, the flags of each port clear a few cycles late and never early.

The read port works in first-word-fall-through style. `out_ready` high means a valid word already sits on `rd_data`, and a read consumes it. The reader can set a mark at its current consumption point. A later retransmit pulse rewinds reading to that mark, so the words after it are delivered again. Words between the mark and the read position stay protected, so storage is released back to the writer only when the mark advances. The almost-full and almost-empty thresholds default to 8. Between reset and the first data write they can be loaded in parallel from the write data bus, or shifted in one bit per clock through a serial input.

Top module: `xfifo_rtx`

## Requirements
- R1: Words leave the read port in the order they were accepted. With no storage released, `in_ready` stays high through the 1023rd accepted word and falls exactly when the 1024th is accepted.
- R2: A write presented while `in_ready` is low is dropped and never appears at the read port.
- R3: `out_ready` is high only while a valid word is on `rd_data`. A read while `out_ready` is low delivers nothing and changes no state.
- R4: `almost_full` is high exactly when the free space (1024 minus the words not yet released) is at or below the almost-full offset.
- R5: `almost_empty` is high exactly when the words visible to the reader and not yet consumed number at or below the almost-empty offset.
- R6: Before the first data write, `prog_en` high together with `wr_en` loads the almost-full offset from `wr_data[9:0]` and the almost-empty offset from `wr_data[19:10]`. That word is not stored in the FIFO.
- R7: Before the first data write, each `wr_clk` cycle with `ser_en` high shifts `ser_in` into the low end of a 20-bit offset register. After 20 shifts, the first bit sent is the most significant bit of the almost-empty offset, and the last bit sent is bit 0 of the almost-full offset.
- R8: After reset both offsets are 8. Once the first data word has been accepted, parallel and serial offset loading are ignored.
- R9: A `mark` pulse records the current consumption point; a read in the same cycle falls after that point. A `retx` pulse rewinds reading to the last mark and clears `out_ready` in the cycle after it. `retx` overrides a `mark` or read in the same cycle. The mark is 0 after reset.
- R10: Consuming words does not free storage. Space is returned to the writer only as the mark advances, one word per read-clock cycle plus the synchronizer delay.
- R11: Data transfer and flags are correct both with independent clocks of different frequency and with one clock driving both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write enable |
| wr_data | input | 36 | Write data; also the offset word during parallel load |
| prog_en | input | 1 | With `wr_en`, treat the write as an offset load |
| ser_en | input | 1 | Shift enable for serial offset loading |
| ser_in | input | 1 | Serial offset bit |
| in_ready | output | 1 | Space available; writes accepted |
| almost_full | output | 1 | Free space at or below the almost-full offset |
| rd_clk | input | 1 | Read-port clock |
| rd_en | input | 1 | Consume the word on `rd_data` |
| mark | input | 1 | Record the current consumption point |
| retx | input | 1 | Rewind reading to the recorded mark |
| rd_data | output | 36 | Read data, valid while `out_ready` is high |
| out_ready | output | 1 | A valid word is on `rd_data` |
| almost_empty | output | 1 | Stored unconsumed words at or below the almost-empty offset |

## Verification
A corrupted write pointer or synchronized free pointer shows as an `in_ready` or `almost_full` value that is off by one at the exact fill level checked, on the write clock edge right after the write. A corrupted read-side pointer or mark shows on the next consumed word, as a value out of order, a missing word or a duplicated word; the scoreboard flags it on the cycle of that read. Offset loading errors show as `almost_empty` taking the wrong value a synchronizer delay after the words that should cross the threshold.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
   localparam int unsigned OFS_DEFAULT = 8;

   function automatic logic [31:0] bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray2bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction
endpackage

// File: rtl/xfifo_dpram.sv
`timescale 1ns/1ps
module xfifo_dpram #(
   parameter int unsigned DW = 36,
   parameter int unsigned AW = 10
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rd_clk,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rd_clk) begin
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/xfifo_gsync.sv
`timescale 1ns/1ps
module xfifo_gsync
   import xfifo_pkg::*;
#(
   parameter int unsigned PW     = 11,
   parameter int unsigned STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] gray_in,
   output logic [PW-1:0] bin_out
);
   logic [STAGES-1:0][PW-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], gray_in};
   end

   assign bin_out = PW'(gray2bin(32'(stg[STAGES-1])));
endmodule

// File: rtl/xfifo_wr_ctl.sv
`timescale 1ns/1ps
module xfifo_wr_ctl
   import xfifo_pkg::*;
#(
   parameter int unsigned AW = 10
) (
   input  logic          wr_clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          prog_en,
   input  logic [2*AW-1:0] prog_word,
   input  logic          ser_en,
   input  logic          ser_in,
   input  logic [AW:0]   free_bin,
   output logic          ram_we,
   output logic [AW-1:0] ram_waddr,
   output logic [AW:0]   wptr_gray,
   output logic          in_ready,
   output logic          almost_full,
   output logic [AW-1:0] ae_ofs
);
   localparam int unsigned PW = AW + 1;
   localparam int unsigned OW = AW;
   localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};
   localparam logic [OW-1:0] OFS_RST  = OW'(OFS_DEFAULT);

   logic [PW-1:0]   wptr_q, wptr_nx, wcount, space;
   logic [2*OW-1:0] ofs_q;
   logic            started_q, push;

   assign wcount      = wptr_q - free_bin;
   assign space       = FULL_CNT - wcount;
   assign in_ready    = (wcount != FULL_CNT);
   assign almost_full = (space <= {1'b0, ofs_q[OW-1:0]});
   assign ae_ofs      = ofs_q[2*OW-1:OW];
   assign push        = wr_en && !prog_en && in_ready;
   assign wptr_nx     = wptr_q + PW'(1);
   assign ram_we      = push;
   assign ram_waddr   = wptr_q[AW-1:0];

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q    <= '0;
         wptr_gray <= '0;
         started_q <= 1'b0;
         ofs_q     <= {OFS_RST, OFS_RST};
      end else begin
         if (push) begin
            wptr_q    <= wptr_nx;
            wptr_gray <= PW'(bin2gray(32'(wptr_nx)));
            started_q <= 1'b1;
         end
         if (!started_q) begin
            if (prog_en && wr_en) ofs_q <= prog_word;
            else if (ser_en)      ofs_q <= {ofs_q[2*OW-2:0], ser_in};
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
      wcount <= FULL_CNT); // R1
   AST_WR_BLOCKED: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_en && !in_ready) |=> (wptr_q == $past(wptr_q))); // R2
   AST_PROG_LOCK: assert property (@(posedge wr_clk) disable iff (!rst_n)
      started_q |=> $stable(ofs_q)); // R8
endmodule

// File: rtl/xfifo_rd_ctl.sv
`timescale 1ns/1ps
module xfifo_rd_ctl
   import xfifo_pkg::*;
#(
   parameter int unsigned AW = 10
) (
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          mark,
   input  logic          retx,
   input  logic [AW:0]   wr_bin,
   input  logic [AW-1:0] ae_ofs,
   output logic          ram_re,
   output logic [AW-1:0] ram_raddr,
   output logic          out_ready,
   output logic          almost_empty,
   output logic [AW:0]   free_gray
);
   localparam int unsigned PW = AW + 1;
   localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};

   logic [PW-1:0] rptr_q, mark_q, free_q, free_nx, cons, avail, stored;
   logic          or_q, take, load;

   assign cons         = rptr_q - {{AW{1'b0}}, or_q};
   assign avail        = wr_bin - rptr_q;
   assign stored       = wr_bin - cons;
   assign take         = or_q && rd_en;
   assign load         = !retx && (avail != '0) && (!or_q || take);
   assign free_nx      = free_q + PW'(1);
   assign ram_re       = load;
   assign ram_raddr    = rptr_q[AW-1:0];
   assign out_ready    = or_q;
   assign almost_empty = (stored <= {1'b0, ae_ofs});

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q    <= '0;
         or_q      <= 1'b0;
         mark_q    <= '0;
         free_q    <= '0;
         free_gray <= '0;
      end else begin
         if (retx) begin
            rptr_q <= mark_q;
            or_q   <= 1'b0;
         end else if (load) begin
            rptr_q <= rptr_q + PW'(1);
            or_q   <= 1'b1;
         end else if (take) begin
            or_q   <= 1'b0;
         end
         if (mark && !retx) mark_q <= cons;
         if (free_q != mark_q) begin
            free_q    <= free_nx;
            free_gray <= PW'(bin2gray(32'(free_nx)));
         end
      end
   end

   AST_OR_HAS_DATA: assert property (@(posedge rd_clk) disable iff (!rst_n)
      or_q |-> (stored != '0)); // R3
   AST_EMPTY_READ: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_en && !or_q && avail == '0 && !retx) |=> $stable(rptr_q)); // R3
   AST_RTX_RELOAD: assert property (@(posedge rd_clk) disable iff (!rst_n)
      retx |=> (rptr_q == $past(mark_q) && !or_q)); // R9
   AST_MARK_BEHIND: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (cons - mark_q) <= FULL_CNT); // R9
   AST_FREE_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (free_q == $past(free_q)) || (free_q == $past(free_q) + PW'(1))); // R10
endmodule

// File: rtl/xfifo_rtx.sv
`timescale 1ns/1ps
module xfifo_rtx #(
   parameter int unsigned DATA_W      = 36,
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              prog_en,
   input  logic              ser_en,
   input  logic              ser_in,
   output logic              in_ready,
   output logic              almost_full,
   input  logic              rd_clk,
   input  logic              rd_en,
   input  logic              mark,
   input  logic              retx,
   output logic [DATA_W-1:0] rd_data,
   output logic              out_ready,
   output logic              almost_empty
);
   localparam int unsigned PW = ADDR_W + 1;

   if (ADDR_W < 2 || ADDR_W > 20) begin : g_bad_addr_w
      $error("xfifo_rtx: ADDR_W out of range");
   end
   if (DATA_W < 2 * ADDR_W) begin : g_bad_data_w
      $error("xfifo_rtx: DATA_W too narrow for parallel offset load");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xfifo_rtx: SYNC_STAGES must be at least 2");
   end

   logic              ram_we, ram_re;
   logic [ADDR_W-1:0] ram_waddr, ram_raddr, ae_ofs;
   logic [PW-1:0]     wptr_gray, wr_bin_rd, free_gray, free_bin_wr;

   xfifo_wr_ctl #(.AW(ADDR_W)) u_wr (
      .wr_clk      (wr_clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .prog_en     (prog_en),
      .prog_word   (wr_data[2*ADDR_W-1:0]),
      .ser_en      (ser_en),
      .ser_in      (ser_in),
      .free_bin    (free_bin_wr),
      .ram_we      (ram_we),
      .ram_waddr   (ram_waddr),
      .wptr_gray   (wptr_gray),
      .in_ready    (in_ready),
      .almost_full (almost_full),
      .ae_ofs      (ae_ofs)
   );

   xfifo_gsync #(.PW(PW), .STAGES(SYNC_STAGES)) u_wsync (
      .clk     (rd_clk),
      .rst_n   (rst_n),
      .gray_in (wptr_gray),
      .bin_out (wr_bin_rd)
   );

   xfifo_gsync #(.PW(PW), .STAGES(SYNC_STAGES)) u_fsync (
      .clk     (wr_clk),
      .rst_n   (rst_n),
      .gray_in (free_gray),
      .bin_out (free_bin_wr)
   );

   xfifo_rd_ctl #(.AW(ADDR_W)) u_rd (
      .rd_clk       (rd_clk),
      .rst_n        (rst_n),
      .rd_en        (rd_en),
      .mark         (mark),
      .retx         (retx),
      .wr_bin       (wr_bin_rd),
      .ae_ofs       (ae_ofs),
      .ram_re       (ram_re),
      .ram_raddr    (ram_raddr),
      .out_ready    (out_ready),
      .almost_empty (almost_empty),
      .free_gray    (free_gray)
   );

   xfifo_dpram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
      .wr_clk (wr_clk),
      .we     (ram_we),
      .waddr  (ram_waddr),
      .wdata  (wr_data),
      .rd_clk (rd_clk),
      .re     (ram_re),
      .raddr  (ram_raddr),
      .rdata  (rd_data)
   );
endmodule

// File: tb/xfifo_rtx_tb.sv
`timescale 1ns/1ps
module xfifo_rtx_tb;
   localparam int DW = 36;
   localparam int AW = 10;
   localparam int DEPTH = 1 << AW;

   logic          wr_clk = 0, rd_clk = 0, rst_n = 0;
   logic          wr_en = 0, prog_en = 0, ser_en = 0, ser_in = 0;
   logic          rd_en = 0, mark = 0, retx = 0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          in_ready, almost_full, out_ready, almost_empty;
   real           rd_half = 6.5;

   always #5 wr_clk = ~wr_clk;
   always #(rd_half) rd_clk = ~rd_clk;

   xfifo_rtx u_dut (
      .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .prog_en(prog_en), .ser_en(ser_en), .ser_in(ser_in),
      .in_ready(in_ready), .almost_full(almost_full),
      .rd_clk(rd_clk), .rd_en(rd_en), .mark(mark), .retx(retx),
      .rd_data(rd_data), .out_ready(out_ready), .almost_empty(almost_empty)
   );

   int            total = 0, bad = 0, consumed = 0;
   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] hist_q[$];

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   // Scoreboard monitor: sampled at the falling read edge, before the rising edge acts
   always @(negedge rd_clk) begin
      if (rst_n) begin
         if (retx) begin
            exp_q = {hist_q, exp_q};
            hist_q.delete();
         end else begin
            if (mark) hist_q.delete();
            if (rd_en && out_ready) begin
               if (exp_q.size() == 0)
                  check(0, "R3", "word delivered with none expected", longint'(rd_data), 0);
               else begin
                  check(rd_data == exp_q[0], "R1", "word order", longint'(rd_data), longint'(exp_q[0]));
                  hist_q.push_back(exp_q.pop_front());
               end
               consumed++;
            end
         end
      end
   end

   initial begin
      #1_000_000;
      check(0, "WD", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic rwait(input int n);
      repeat (n) @(posedge rd_clk);
      #1;
   endtask

   task automatic wwait(input int n);
      repeat (n) @(posedge wr_clk);
      #1;
   endtask

   task automatic wr_word(input logic [DW-1:0] d, input bit acc);
      @(posedge wr_clk); #1;
      wr_en = 1; prog_en = 0; wr_data = d;
      if (acc) exp_q.push_back(d);
   endtask

   task automatic wr_idle();
      @(posedge wr_clk); #1;
      wr_en = 0; prog_en = 0;
   endtask

   task automatic wr_burst(input int n, input logic [DW-1:0] base);
      for (int i = 0; i < n; i++) wr_word(base + DW'(i), 1'b1);
      wr_idle();
   endtask

   task automatic prog_word(input int ae, input int af);
      @(posedge wr_clk); #1;
      wr_en = 1; prog_en = 1;
      wr_data = '0;
      wr_data[9:0] = 10'(af);
      wr_data[19:10] = 10'(ae);
      wr_idle();
   endtask

   task automatic ser_load(input logic [19:0] v);
      for (int i = 19; i >= 0; i--) begin
         @(posedge wr_clk); #1;
         ser_en = 1; ser_in = v[i];
      end
      @(posedge wr_clk); #1;
      ser_en = 0; ser_in = 0;
   endtask

   task automatic rd_words(input int n);
      int target;
      target = consumed + n;
      @(posedge rd_clk); #1;
      rd_en = 1;
      while (consumed < target) begin
         @(posedge rd_clk); #1;
      end
      rd_en = 0;
   endtask

   task automatic pulse_mark();
      @(posedge rd_clk); #1; mark = 1;
      @(posedge rd_clk); #1; mark = 0;
   endtask

   task automatic pulse_retx();
      @(posedge rd_clk); #1; retx = 1;
      @(posedge rd_clk); #1; retx = 0;
   endtask

   task automatic do_reset(input real half);
      rst_n = 0;
      wr_en = 0; prog_en = 0; ser_en = 0; ser_in = 0;
      rd_en = 0; mark = 0; retx = 0;
      rd_half = half;
      #60;
      exp_q.delete();
      hist_q.delete();
      @(posedge wr_clk); #1;
      rst_n = 1;
      rwait(2);
   endtask

   initial begin
      // ---------------- phase 1: unrelated clocks ----------------
      do_reset(6.5);
      check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
      check(out_ready == 0, "R3", "out_ready after reset", out_ready, 0);
      check(almost_full == 0, "R4", "almost_full after reset", almost_full, 0);
      check(almost_empty == 1, "R5", "almost_empty after reset", almost_empty, 1);

      prog_word(2, 4);                       // R6: ae=2, af=4
      rwait(10);
      check(out_ready == 0, "R6", "offset word must not be stored", out_ready, 0);

      wr_burst(3, 36'h0_0000_0010);
      rwait(8);
      check(almost_empty == 0, "R6", "3 stored above ae=2", almost_empty, 0);
      check(out_ready == 1, "R3", "word waiting on output", out_ready, 1);
      rd_words(1);
      rwait(3);
      check(almost_empty == 1, "R5", "2 stored at ae=2", almost_empty, 1);
      rd_words(2);
      rwait(3);
      check(out_ready == 0, "R3", "drained", out_ready, 0);
      @(posedge rd_clk); #1; rd_en = 1;      // R3: read with nothing ready
      @(posedge rd_clk); #1; rd_en = 0;
      rwait(2);
      check(out_ready == 0, "R3", "empty read leaves output idle", out_ready, 0);

      pulse_mark();
      rwait(12);

      for (int i = 0; i < 1019; i++) wr_word(36'h1_0000_0000 + 36'(i), 1'b1);
      wr_idle();
      check(almost_full == 0, "R4", "free space 5 above af=4", almost_full, 0);
      wr_burst(1, 36'h1_0000_1000);
      check(almost_full == 1, "R4", "free space 4 at af=4", almost_full, 1);
      wr_burst(3, 36'h1_0000_2000);
      check(in_ready == 1, "R1", "1023 words still accepted", in_ready, 1);
      wr_burst(1, 36'h1_0000_3000);
      check(in_ready == 0, "R1", "full at 1024 words", in_ready, 0);
      wr_word(36'hF_FFFF_FFFF, 1'b0);        // R2: dropped write
      wr_idle();
      check(in_ready == 0, "R2", "still full after dropped write", in_ready, 0);

      rd_words(DEPTH);
      rwait(6);
      check(out_ready == 0, "R2", "dropped word never delivered", out_ready, 0);
      check(exp_q.size() == 0, "R1", "all words delivered", exp_q.size(), 0);
      wwait(20);
      check(in_ready == 0, "R10", "reads alone free no space", in_ready, 0);
      pulse_mark();
      rwait(1100);
      wwait(4);
      check(in_ready == 1, "R10", "space back after mark", in_ready, 1);
      check(almost_full == 0, "R10", "almost_full clear after release", almost_full, 0);

      wr_burst(10, 36'h2_0000_0000);
      rwait(8);
      rd_words(5);
      pulse_mark();
      rd_words(3);
      pulse_retx();
      check(out_ready == 0, "R9", "output cleared by retransmit", out_ready, 0);
      check(exp_q.size() == 5, "R9", "words pending after rewind", exp_q.size(), 5);
      rd_words(5);
      rwait(4);
      check(exp_q.size() == 0, "R9", "replayed words delivered", exp_q.size(), 0);
      check(out_ready == 0, "R3", "drained after replay", out_ready, 0);

      // ---------------- phase 2: one clock for both ports ----------------
      do_reset(5.0);
      ser_load(20'((1 << 10) | 2));          // R7: ae=1, af=2
      wr_burst(2, 36'h3_0000_0000);
      rwait(8);
      check(almost_empty == 0, "R7", "2 stored above serial ae=1", almost_empty, 0);
      check(almost_full == 0, "R7", "free space above serial af=2", almost_full, 0);
      rd_words(1);
      rwait(3);
      check(almost_empty == 1, "R7", "1 stored at serial ae=1", almost_empty, 1);
      prog_word(500, 500);                   // R8: must be ignored now
      wr_burst(1, 36'h3_0000_0100);
      rwait(8);
      check(almost_empty == 0, "R8", "late offset load ignored", almost_empty, 0);
      rd_words(2);
      rwait(4);
      check(exp_q.size() == 0, "R11", "coincident clocks deliver all", exp_q.size(), 0);

      // ---------------- phase 3: fast reader, default offsets ----------------
      do_reset(3.5);
      wr_burst(8, 36'h4_0000_0000);
      rwait(8);
      check(almost_empty == 1, "R8", "8 stored at default ae=8", almost_empty, 1);
      ser_load(20'h00000);                   // R8: ignored after first write
      wr_burst(1, 36'h4_0000_0100);
      rwait(8);
      check(almost_empty == 0, "R8", "9 stored above default ae=8", almost_empty, 0);
      rd_words(9);
      rwait(4);
      check(exp_q.size() == 0, "R11", "fast reader delivers all", exp_q.size(), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule